// File: doc/BRIEF.md
# Programmable Vertical Sync Pulse Generator

This block makes one gating pulse per video field for a tuner's RF gain loop. The pulse is placed relative to the start of vertical blanking. Two one-cycle strobes drive it: a line strobe at every horizontal line boundary, and a blanking strobe at the start of each vertical blanking interval.

An 8-bit configuration register sets three things:
- the pulse length in lines;
- the level of the pulse's first edge;
- a signed line offset, equal to the delay field minus 12.

A non-negative offset is counted forward from the blanking strobe. A negative offset places the pulse before the next blanking start. For that case the block measures how many line boundaries the last field held, and predicts the next blanking start from that count.

Line positions are counted in boundaries. The blanking strobe is boundary 0 of a field, and each later line strobe is the next boundary. A blanking strobe that arrives together with a line strobe counts as one boundary. An output edge appears in the clock cycle after the boundary that causes it.

The block holds two small state machines.
- Scheduler, states `SC_IDLE` and `SC_ARMED`:
  - A blanking strobe that gives a valid target of 0 fires at once and stays in `SC_IDLE`.
  - A blanking strobe that gives a valid later target moves to `SC_ARMED`.
  - A blanking strobe whose target is invalid goes to `SC_IDLE`.
  - In `SC_ARMED`, reaching the target boundary fires and returns to `SC_IDLE`.
  - In `SC_ARMED`, a line counter overflow returns to `SC_IDLE`.
- Pulse machine, states `PS_REST` and `PS_ACTIVE`:
  - A fire request in `PS_REST` moves to `PS_ACTIVE`.
  - In `PS_ACTIVE`, the boundary that uses up the selected length returns to `PS_REST`.

Top module: `vsync_pulse_gen`

## Requirements
- R1: Out of reset the register reads 0x6F (length code 01, first edge rising, delay 15), and the output rests low. No pulse occurs before the first blanking strobe.
- R2: Bits 7:6 select the pulse length in line boundaries: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 16.
- R3: Bit 5 gives the active level: 1 means active high, 0 means active low. Outside a pulse the output is the inverse of bit 5, and this follows a write from the clock edge that stores it.
- R4: With delay field d (bits 4:0) of 12 or more, the pulse starts at boundary d-12 of the field. The output changes in the cycle after that boundary, so d=12 starts the pulse at the blanking strobe itself.
- R5: With d below 12, the pulse starts at boundary L+d-12. This position is counted from the previous blanking strobe, and L is the number of boundaries in the field that the previous blanking strobe closed.
- R6: A negative offset produces no pulse when any of these holds:
  - no earlier blanking strobe has been seen since reset;
  - the previous field held more than 2^LINE_W-1 line strobes;
  - L+d-12 is below 1.
- R7: The pulse stays active for exactly the selected number of boundaries. Both of its edges occur in the cycle after a boundary.
- R8: A write made during a pulse changes neither that pulse's level nor its length. A start request that falls inside an active pulse is dropped.
- R9: The register reads back the last value written.
- R10: A blanking strobe that arrives with a line strobe counts as a single boundary, numbered 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb | input | 1 | One-cycle horizontal line boundary strobe |
| vbi_stb | input | 1 | One-cycle start of vertical blanking strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register contents |
| vs_out | output | 1 | V-sync gating pulse |

## Verification
Some properties are checked on every cycle:
- pulse edges occur only in the cycle after a boundary;
- the level holds steady throughout an active pulse;
- the remaining-length counter stays within range;
- an armed target always lies ahead of the current line index;
- a negative offset never arms without a valid measurement;
- the register reads back what was written.

Other behaviour only the bench scenarios can show, because it needs whole fields of strobes:
- the exact start boundary for positive, zero and negative offsets;
- the mapping of each length code;
- a 16-line pulse that spans a blanking strobe;
- suppression after reset, after an overflowing field and for too-short fields;
- a write made mid-pulse taking effect only in the next field.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int unsigned CFG_W        = 8;
    localparam int unsigned DLY_W        = 5;
    localparam int unsigned REM_W        = 5;
    localparam logic [DLY_W-1:0] DLY_BIAS = 5'd12;

    typedef struct packed {
        logic [1:0]       len_code;
        logic             first_rise;
        logic [DLY_W-1:0] delay;
    } vsg_cfg_t;

    typedef enum logic {
        SC_IDLE  = 1'b0,
        SC_ARMED = 1'b1
    } sched_state_e;

    typedef enum logic {
        PS_REST   = 1'b0,
        PS_ACTIVE = 1'b1
    } pulse_state_e;

    function automatic logic [REM_W-1:0] len_lines(input logic [1:0] code);
        logic [REM_W-1:0] n;
        unique case (code)
            2'b00: n = 5'd1;
            2'b01: n = 5'd2;
            2'b10: n = 5'd4;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vsg_line_tracker.sv
module vsg_line_tracker
    import vsg_pkg::*;
#(
    parameter int unsigned LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              vbi_stb,
    output logic              bnd,
    output logic [LINE_W-1:0] pos_cur,
    output logic [LINE_W-1:0] pos_next,
    output logic [LINE_W:0]   meas_len,
    output logic              meas_ok,
    output logic              sat
);

    localparam logic [LINE_W-1:0] IDX_MAX = '1;

    logic [LINE_W-1:0] idx_q;
    logic              seen_q;
    logic              sat_q;

    assign bnd = line_stb | vbi_stb;

    always_comb begin
        if (vbi_stb) begin
            pos_next = '0;
        end else if (idx_q == IDX_MAX) begin
            pos_next = IDX_MAX;
        end else begin
            pos_next = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            seen_q <= 1'b0;
            sat_q  <= 1'b0;
        end else if (bnd) begin
            idx_q <= pos_next;
            if (vbi_stb) begin
                seen_q <= 1'b1;
                sat_q  <= 1'b0;
            end else if (idx_q == IDX_MAX) begin
                sat_q <= 1'b1;
            end
        end
    end

    assign pos_cur  = idx_q;
    assign meas_len = {1'b0, idx_q} + 1'b1;
    assign meas_ok  = seen_q & ~sat_q;
    assign sat      = sat_q;

    // R10: a blanking strobe always restarts the index at 0
    a_r10_vbi_restart: assert property (@(posedge clk) disable iff (!rst_n)
        vbi_stb |=> (idx_q == '0));

    // R6: an overflow stays flagged until the next blanking strobe
    a_r6_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_q && !vbi_stb) |=> sat_q);

endmodule

// File: rtl/vsg_scheduler.sv
module vsg_scheduler
    import vsg_pkg::*;
#(
    parameter int unsigned LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnd,
    input  logic              vbi_stb,
    input  logic [LINE_W-1:0] pos_cur,
    input  logic [LINE_W-1:0] pos_next,
    input  logic [LINE_W:0]   meas_len,
    input  logic              meas_ok,
    input  logic              sat,
    input  logic [DLY_W-1:0]  delay,
    output logic              fire
);

    localparam int unsigned SUM_W = LINE_W + 2;
    localparam logic [SUM_W-1:0] NEG_MIN  = SUM_W'(DLY_BIAS) + 1'b1;
    localparam logic [SUM_W-1:0] BIAS_EXT = SUM_W'(DLY_BIAS);

    sched_state_e      state_q, state_d;
    logic [LINE_W-1:0] tgt_q, tgt_d;
    logic              fire_d;

    logic              ahead;
    logic [DLY_W-1:0]  dly_off;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  sum_off;
    logic              new_ok;
    logic [LINE_W-1:0] new_tgt;

    // target for the field that the current blanking strobe opens
    always_comb begin
        ahead   = (delay >= DLY_BIAS);
        dly_off = delay - DLY_BIAS;
        sum     = {1'b0, meas_len} + SUM_W'(delay);
        sum_off = sum - BIAS_EXT;
        if (ahead) begin
            new_ok  = 1'b1;
            new_tgt = LINE_W'(dly_off);
        end else begin
            new_ok  = meas_ok && (sum >= NEG_MIN);
            new_tgt = sum_off[LINE_W-1:0];
        end
    end

    // transition decode
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        fire_d  = 1'b0;
        if (vbi_stb) begin
            if (new_ok && (new_tgt == '0)) begin
                fire_d  = 1'b1;
                state_d = SC_IDLE;
            end else if (new_ok) begin
                state_d = SC_ARMED;
                tgt_d   = new_tgt;
            end else begin
                state_d = SC_IDLE;
            end
        end else begin
            unique case (state_q)
                SC_IDLE: begin
                    state_d = SC_IDLE;
                end
                SC_ARMED: begin
                    if (bnd && (pos_next == tgt_q)) begin
                        fire_d  = 1'b1;
                        state_d = SC_IDLE;
                    end else if (sat) begin
                        state_d = SC_IDLE;
                    end
                end
                default: state_d = SC_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // outputs
    always_comb begin
        fire = fire_d;
    end

    // R6: a negative offset with no valid measurement leaves nothing armed
    a_r6_no_meas_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (vbi_stb && (delay < DLY_BIAS) && !meas_ok) |=> (state_q == SC_IDLE));

    // R5: an armed target always lies ahead of the current line index
    a_r5_target_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_ARMED) |-> (tgt_q > pos_cur));

    // R4: a start request only ever coincides with a boundary
    a_r4_fire_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> bnd);

endmodule

// File: rtl/vsg_pulse_fsm.sv
module vsg_pulse_fsm
    import vsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bnd,
    input  logic       fire,
    input  logic [1:0] len_code,
    input  logic       first_rise,
    output logic       vs_out
);

    pulse_state_e     state_q, state_d;
    logic [REM_W-1:0] rem_q, rem_d;
    logic             lvl_q, lvl_d;
    logic             act;

    // transition decode
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            PS_REST: begin
                if (fire) begin
                    state_d = PS_ACTIVE;
                    rem_d   = len_lines(len_code);
                    lvl_d   = first_rise;
                end
            end
            PS_ACTIVE: begin
                if (bnd) begin
                    if (rem_q == 5'd1) begin
                        state_d = PS_REST;
                        rem_d   = '0;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
            end
            default: state_d = PS_REST;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_REST;
            rem_q   <= '0;
            lvl_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            lvl_q   <= lvl_d;
        end
    end

    // outputs
    always_comb begin
        act = (state_q == PS_ACTIVE);
        if (act) begin
            vs_out = lvl_q;
        end else begin
            vs_out = ~first_rise;
        end
    end

    // R7: pulse edges follow a boundary
    a_r7_edge_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act) || $fell(act)) |-> $past(bnd));

    // R8: the level is held for the whole pulse, whatever is written meanwhile
    a_r8_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act)) |-> $stable(vs_out));

    // R7: the remaining length stays in range while active
    a_r7_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> ((rem_q != '0) && (rem_q <= 5'd16)));

endmodule

// File: rtl/vsync_pulse_gen.sv
module vsync_pulse_gen
    import vsg_pkg::*;
#(
    parameter int unsigned LINE_W    = 10,
    parameter logic [7:0]  CFG_RESET = 8'h6F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb,
    input  logic       vbi_stb,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       vs_out
);

    vsg_cfg_t          cfg_q;
    logic              bnd;
    logic [LINE_W-1:0] pos_cur;
    logic [LINE_W-1:0] pos_next;
    logic [LINE_W:0]   meas_len;
    logic              meas_ok;
    logic              sat;
    logic              fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= vsg_cfg_t'(CFG_RESET);
        end else if (cfg_we) begin
            cfg_q <= vsg_cfg_t'(cfg_wdata);
        end
    end

    assign cfg_rdata = cfg_q;

    vsg_line_tracker #(.LINE_W(LINE_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .vbi_stb  (vbi_stb),
        .bnd      (bnd),
        .pos_cur  (pos_cur),
        .pos_next (pos_next),
        .meas_len (meas_len),
        .meas_ok  (meas_ok),
        .sat      (sat)
    );

    vsg_scheduler #(.LINE_W(LINE_W)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .bnd      (bnd),
        .vbi_stb  (vbi_stb),
        .pos_cur  (pos_cur),
        .pos_next (pos_next),
        .meas_len (meas_len),
        .meas_ok  (meas_ok),
        .sat      (sat),
        .delay    (cfg_q.delay),
        .fire     (fire)
    );

    vsg_pulse_fsm u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .bnd        (bnd),
        .fire       (fire),
        .len_code   (cfg_q.len_code),
        .first_rise (cfg_q.first_rise),
        .vs_out     (vs_out)
    );

    // R9: a write is visible on the read port from the next cycle
    a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

endmodule

// File: tb/tb_vsync_pulse_gen.sv
module tb_vsync_pulse_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       vbi_stb = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       vs_out;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int base = 0;
    logic mon_on = 1'b0;
    logic prev = 1'b0;

    typedef struct {
        int    t;
        logic  lvl;
        string tag;
    } exp_t;
    exp_t q[$];

    vsync_pulse_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_stb  (line_stb),
        .vbi_stb   (vbi_stb),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .vs_out    (vs_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_edge(input int t, input logic lvl, input string tag);
        exp_t e;
        e.t = t; e.lvl = lvl; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: every output edge is compared with the scoreboard front
    always @(negedge clk) begin
        if (mon_on && (vs_out !== prev)) begin
            checks++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL unexpected edge: actual level %0b at cycle %0d, expected no edge", vs_out, cyc);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.t != cyc || e.lvl !== vs_out) begin
                    bad++;
                    $display("FAIL %s: actual level %0b at cycle %0d, expected level %0b at cycle %0d",
                             e.tag, vs_out, cyc, e.lvl, e.t);
                end
            end
            prev = vs_out;
        end
    end

    task automatic drain(input string tag);
        checks++;
        if (q.size() != 0) begin
            bad++;
            while (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                $display("FAIL %s: actual no edge, expected level %0b at cycle %0d", tag, e.lvl, e.t);
            end
        end
    endtask

    task automatic chk8(input logic [7:0] act, input logic [7:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    // n boundaries, 4 cycles apart; optional write in iteration wat
    task automatic emit(input int n, input logic with_vbi, input int wat, input logic [7:0] wd);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_stb = 1'b1;
            vbi_stb  = with_vbi && (i == 0);
            @(negedge clk);
            line_stb = 1'b0;
            vbi_stb  = 1'b0;
            if (i == wat) begin
                cfg_we = 1'b1;
                cfg_wdata = wd;
            end
            @(negedge clk);
            cfg_we = 1'b0;
            @(negedge clk);
        end
    endtask

    // write outside the line sequence; returns the cycle the write lands
    task automatic wr(input logic [7:0] d, output int t);
        t = cyc + 2;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog: actual run still going, expected completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int tw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk8(cfg_rdata, 8'h6F, "R1 reset register");
        chk8({7'd0, vs_out}, 8'h00, "R1 reset level");
        prev = vs_out;
        mon_on = 1'b1;

        // R1: no pulse before the first blanking strobe
        emit(10, 1'b0, -1, 8'h00);
        drain("R1 no pulse before blanking");

        // R4 R2 R10: default delay 15 -> boundary 3, length 2
        base = cyc + 2;
        expect_edge(base + 4*3, 1'b1, "R4 default start");
        expect_edge(base + 4*5, 1'b0, "R2 default length");
        emit(20, 1'b1, -1, 8'h00);
        drain("R10 default field");

        // R4 offset 0, R2 length code 00
        wr(8'h2C, tw);
        base = cyc + 2;
        expect_edge(base, 1'b1, "R4 offset zero start");
        expect_edge(base + 4, 1'b0, "R2 code 00");
        emit(20, 1'b1, -1, 8'h00);
        drain("R2 code 00");

        // R2 code 10
        wr(8'hAC, tw);
        base = cyc + 2;
        expect_edge(base, 1'b1, "R4 offset zero start");
        expect_edge(base + 4*4, 1'b0, "R2 code 10");
        emit(20, 1'b1, -1, 8'h00);
        drain("R2 code 10");

        // R2 code 11
        wr(8'hEC, tw);
        base = cyc + 2;
        expect_edge(base, 1'b1, "R4 offset zero start");
        expect_edge(base + 4*16, 1'b0, "R2 code 11");
        emit(20, 1'b1, -1, 8'h00);
        drain("R2 code 11");

        // R4 largest delay 31 -> boundary 19
        wr(8'h3F, tw);
        base = cyc + 2;
        expect_edge(base + 4*19, 1'b1, "R4 delay 31 start");
        expect_edge(base + 4*20, 1'b0, "R7 delay 31 end");
        emit(21, 1'b1, -1, 8'h00);
        drain("R4 delay 31");

        // R3 polarity: rest level follows at once, pulse active low
        wr(8'h4F, tw);
        expect_edge(tw, 1'b1, "R3 rest level flips");
        chk8(cfg_rdata, 8'h4F, "R9 readback");
        base = cyc + 2;
        expect_edge(base + 4*3, 1'b0, "R3 active low start");
        expect_edge(base + 4*5, 1'b1, "R3 active low end");
        emit(20, 1'b1, -1, 8'h00);
        wr(8'h6F, tw);
        expect_edge(tw, 1'b0, "R3 rest level restores");
        @(negedge clk);
        drain("R3 polarity");

        // R8: write during a 16-line pulse takes effect next field
        wr(8'hEF, tw);
        base = cyc + 2;
        expect_edge(base + 4*3, 1'b1, "R8 long pulse start");
        expect_edge(base + 4*19, 1'b0, "R8 long pulse kept");
        expect_edge(base + 4*23, 1'b1, "R8 new config start");
        expect_edge(base + 4*24, 1'b0, "R8 new config length");
        emit(20, 1'b1, 8, 8'h2F);
        emit(20, 1'b1, -1, 8'h00);
        drain("R8 write mid pulse");
        chk8(cfg_rdata, 8'h2F, "R9 readback of mid-pulse write");

        // R5 negative offset: d=9, L=20 -> boundary 17
        wr(8'h69, tw);
        base = cyc + 2;
        expect_edge(base + 4*17, 1'b1, "R5 negative start");
        expect_edge(base + 4*19, 1'b0, "R5 negative end");
        expect_edge(base + 4*37, 1'b1, "R5 negative start 2");
        expect_edge(base + 4*39, 1'b0, "R5 negative end 2");
        emit(20, 1'b1, -1, 8'h00);
        emit(20, 1'b1, -1, 8'h00);
        drain("R5 negative offset");

        // R7 R8: 16-line pulse straddles a blanking strobe
        wr(8'hE9, tw);
        base = cyc + 2;
        expect_edge(base + 4*17, 1'b1, "R7 straddle start");
        expect_edge(base + 4*33, 1'b0, "R7 straddle end");
        expect_edge(base + 4*37, 1'b1, "R7 next start");
        expect_edge(base + 4*53, 1'b0, "R7 next end");
        emit(20, 1'b1, -1, 8'h00);
        emit(20, 1'b1, -1, 8'h00);
        emit(20, 1'b0, -1, 8'h00);
        drain("R7 straddle");

        // R6 overflowing field suppresses the next negative pulse
        wr(8'h69, tw);
        base = cyc + 2;
        expect_edge(base + 4*37, 1'b1, "R5 start from 40-line field");
        expect_edge(base + 4*39, 1'b0, "R5 end from 40-line field");
        emit(1, 1'b1, -1, 8'h00);
        emit(1200, 1'b0, -1, 8'h00);
        emit(1, 1'b1, -1, 8'h00);
        emit(30, 1'b0, -1, 8'h00);
        drain("R6 overflow suppress");

        // R6 first field after reset suppressed, R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk8(cfg_rdata, 8'h6F, "R1 register after reset");
        chk8({7'd0, vs_out}, 8'h00, "R1 level after reset");
        wr(8'h69, tw);
        base = cyc + 2;
        expect_edge(base + 4*37, 1'b1, "R6 second field start");
        expect_edge(base + 4*39, 1'b0, "R6 second field end");
        emit(20, 1'b1, -1, 8'h00);
        emit(20, 1'b1, -1, 8'h00);
        drain("R6 no measurement after reset");

        // R6 too-short field: d=0, L=12 -> L+d-12 = 0 suppressed
        wr(8'h60, tw);
        base = cyc + 2;
        expect_edge(base + 4*8, 1'b1, "R5 d0 from 20-line field");
        expect_edge(base + 4*10, 1'b0, "R5 d0 end");
        emit(12, 1'b1, -1, 8'h00);
        emit(12, 1'b1, -1, 8'h00);
        emit(12, 1'b1, -1, 8'h00);
        emit(12, 1'b0, -1, 8'h00);
        drain("R6 short field suppress");

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule